// File: doc/BRIEF.md
# Token Bucket Traffic Regulator

This block meters a stream of packet descriptors against a single token bucket described by a fill rate and a depth. The bucket gains a fixed-point amount of credit every clock and is capped at the configured depth. Each token is worth one byte. Over any window of t clocks, the bytes the block lets through as conforming never exceed the depth plus the rate times t.

The bucket can work in one of two ways, chosen by one configuration input.

- **Shaper mode.** An accepted descriptor is held in a single pending slot until the bucket has enough credit for it. It then leaves with the conform flag set, and its length is charged to the bucket.
- **Policer mode.** Each descriptor is judged in the cycle it arrives and is passed on one clock later. Its conform flag tells downstream logic whether to keep, remark or drop it. Only conforming descriptors are charged.

A descriptor carries only a byte length. Payload storage stays outside the block.

Top module: `token_bucket_regulator`

## Requirements
- R1: While reset is held and just after it, the bucket holds exactly `cfg_depth` tokens, `in_ready` is 1 and `out_valid` is 0.
- R2: Every clock adds `cfg_rate` to the bucket. `cfg_rate` is unsigned fixed point with 8 fractional bits, so 0x0080 is half a token per clock. Fractions carry over from clock to clock.
- R3: The token count never exceeds `cfg_depth`. Credit above the depth is lost.
- R4: A descriptor conforms only when the whole-token count is at least its length. A length of 0 always conforms. A conforming descriptor has its full length deducted in one step.
- R5: In policer mode (`cfg_police` = 1), a descriptor accepted at a clock edge appears on `out_valid` after the next edge. It carries the same length and its conform verdict.
- R6: In policer mode, a non-conforming descriptor is still passed on, with `out_conform` = 0, and removes no tokens.
- R7: In shaper mode (`cfg_police` = 0), an accepted descriptor waits in one pending slot, and `in_ready` is 0 while it waits. It is released with `out_conform` = 1 at the first edge where the bucket held enough tokens at the start of that clock, which is at least one edge after acceptance.
- R8: In shaper mode, a descriptor longer than `cfg_depth` can never gather enough tokens. It stays pending and blocks input until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads a full bucket |
| cfg_police | input | 1 | 1 = mark without delay, 0 = delay until conforming |
| cfg_rate | input | RATE_W | Tokens added per clock, 8 fractional bits |
| cfg_depth | input | TOK_W | Bucket capacity in whole tokens (bytes) |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken this clock |
| in_len | input | LEN_W | Descriptor length in bytes |
| out_valid | output | 1 | One-clock pulse carrying a descriptor out |
| out_len | output | LEN_W | Length of the outgoing descriptor |
| out_conform | output | 1 | Descriptor fitted in the bucket |

## Verification
Some properties are checked on every clock by assertions:

- the bucket never rises above the depth seen on the previous clock;
- a deduction never exceeds the tokens on hand;
- a waiting shaper descriptor keeps its length until it leaves;
- every release from the pending slot is a conforming output pulse.

Other behaviour can only be shown by the bench scenarios, which drive known sequences and compare the results:

- the exact conform verdicts across a draining bucket;
- fractional credit building up into whole tokens at half a token per clock;
- the cap that throws away surplus credit;
- the release latency in shaper mode as the bucket refills;
- the permanent stall of an oversized descriptor.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
    // fractional bits of the rate and of the token accumulator
    localparam int FRAC_W = 8;

    typedef enum logic {
        MODE_SHAPE  = 1'b0,
        MODE_POLICE = 1'b1
    } tbr_mode_e;
endpackage

// File: rtl/tbr_bucket.sv
module tbr_bucket
    import tbr_pkg::*;
#(
    parameter int TOK_W  = 20,
    parameter int RATE_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic [TOK_W-1:0]  depth,
    input  logic              debit_en,
    input  logic [LEN_W-1:0]  debit_len,
    output logic [TOK_W-1:0]  tok_int
);
    localparam int ACC_W = TOK_W + FRAC_W;
    localparam int SUM_W = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] tok;
    } bkt_t;

    bkt_t bkt_d, bkt_q;
    logic [SUM_W-1:0] debit_fx;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] grown;
    logic [SUM_W-1:0] cap_fx;

    always_comb begin
        bkt_d    = bkt_q;
        debit_fx = debit_en ? (SUM_W'(debit_len) << FRAC_W) : '0;
        base     = {1'b0, bkt_q.tok} - debit_fx;
        grown    = base + SUM_W'(rate);
        cap_fx   = SUM_W'(depth) << FRAC_W;
        if (grown > cap_fx) begin
            bkt_d.tok = cap_fx[ACC_W-1:0];
        end else begin
            bkt_d.tok = grown[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkt_q.tok <= ACC_W'(depth) << FRAC_W;
        end else begin
            bkt_q <= bkt_d;
        end
    end

    assign tok_int = bkt_q.tok[ACC_W-1:FRAC_W];

    AST_TOK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        tok_int <= $past(depth)); // R3

    AST_DEBIT_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
        debit_en |-> (tok_int >= TOK_W'(debit_len))); // R4
endmodule

// File: rtl/tbr_gate.sv
module tbr_gate
    import tbr_pkg::*;
#(
    parameter int TOK_W = 20,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tbr_mode_e        mode,
    input  logic             in_valid,
    input  logic [LEN_W-1:0] in_len,
    output logic             in_ready,
    input  logic [TOK_W-1:0] tok_int,
    output logic             debit_en,
    output logic [LEN_W-1:0] debit_len,
    output logic             out_valid,
    output logic [LEN_W-1:0] out_len,
    output logic             out_conform
);
    typedef struct packed {
        logic             pend;
        logic [LEN_W-1:0] pend_len;
        logic             ov;
        logic [LEN_W-1:0] olen;
        logic             oconf;
    } gate_t;

    gate_t g_d, g_q;
    logic  take;
    logic  fits_in;
    logic  fits_pend;

    always_comb begin
        g_d       = g_q;
        g_d.ov    = 1'b0;
        debit_en  = 1'b0;
        debit_len = '0;
        take      = in_valid && !g_q.pend;
        fits_in   = tok_int >= TOK_W'(in_len);
        fits_pend = tok_int >= TOK_W'(g_q.pend_len);
        if (g_q.pend) begin
            if (fits_pend) begin
                g_d.pend  = 1'b0;
                g_d.ov    = 1'b1;
                g_d.olen  = g_q.pend_len;
                g_d.oconf = 1'b1;
                debit_en  = 1'b1;
                debit_len = g_q.pend_len;
            end
        end else if (take) begin
            if (mode == MODE_POLICE) begin
                g_d.ov    = 1'b1;
                g_d.olen  = in_len;
                g_d.oconf = fits_in;
                debit_en  = fits_in;
                debit_len = in_len;
            end else begin
                g_d.pend     = 1'b1;
                g_d.pend_len = in_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign in_ready    = !g_q.pend;
    assign out_valid   = g_q.ov;
    assign out_len     = g_q.olen;
    assign out_conform = g_q.oconf;

    AST_PEND_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.pend) |-> $past(in_valid)); // R7

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.pend && (tok_int < TOK_W'(g_q.pend_len))) |=> (g_q.pend && $stable(g_q.pend_len))); // R8

    AST_RELEASE_CONFORMS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(g_q.pend) |-> (out_valid && out_conform)); // R7
endmodule

// File: rtl/token_bucket_regulator.sv
module token_bucket_regulator
    import tbr_pkg::*;
#(
    parameter int TOK_W  = 20,
    parameter int RATE_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_police,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [TOK_W-1:0]  cfg_depth,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LEN_W-1:0]  in_len,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_conform
);
    logic [TOK_W-1:0] tok_int;
    logic             debit_en;
    logic [LEN_W-1:0] debit_len;
    tbr_mode_e        mode;

    assign mode = cfg_police ? MODE_POLICE : MODE_SHAPE;

    tbr_bucket #(.TOK_W(TOK_W), .RATE_W(RATE_W), .LEN_W(LEN_W)) u_bucket (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate      (cfg_rate),
        .depth     (cfg_depth),
        .debit_en  (debit_en),
        .debit_len (debit_len),
        .tok_int   (tok_int)
    );

    tbr_gate #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .in_valid    (in_valid),
        .in_len      (in_len),
        .in_ready    (in_ready),
        .tok_int     (tok_int),
        .debit_en    (debit_en),
        .debit_len   (debit_len),
        .out_valid   (out_valid),
        .out_len     (out_len),
        .out_conform (out_conform)
    );

    AST_OUT_AFTER_POLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_police) |=> out_valid); // R5
endmodule

// File: tb/test_token_bucket_regulator.sv
module test_token_bucket_regulator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_police;
    logic [15:0] cfg_rate;
    logic [19:0] cfg_depth;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_len;
    logic        out_valid;
    logic [15:0] out_len;
    logic        out_conform;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    token_bucket_regulator i_token_bucket_regulator (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_police  (cfg_police),
        .cfg_rate    (cfg_rate),
        .cfg_depth   (cfg_depth),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_len      (in_len),
        .out_valid   (out_valid),
        .out_len     (out_len),
        .out_conform (out_conform)
    );

    typedef struct packed {
        logic [15:0] len;
        logic        conf;
    } vec_t;

    // policer, depth 100, rate 0: draining a full bucket
    localparam vec_t VEC [5] = '{
        '{16'd60, 1'b1},
        '{16'd50, 1'b0},
        '{16'd40, 1'b1},
        '{16'd0,  1'b1},
        '{16'd1,  1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic police_send(input logic [15:0] len, input logic exp_conf, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_len   = len;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " out_valid"}, int'(out_valid), 1);
        check({tag, " out_conform"}, int'(out_conform), int'(exp_conf));
        check({tag, " out_len"}, int'(out_len), int'(len));
    endtask

    task automatic shape_send(input logic [15:0] len, input int exp_lat);
        int lat;
        @(negedge clk);
        in_valid = 1'b1;
        in_len   = len;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 in_ready low while pending", int'(in_ready), 0);
        lat = 0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (out_valid || lat > 50) break;
        end
        check("R7 release latency", lat, exp_lat);
        check("R7 shaped conform", int'(out_conform), 1);
        check("R7 shaped length", int'(out_len), int'(len));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        cfg_police = 1'b1;
        cfg_rate   = 16'h0000;
        cfg_depth  = 20'd100;
        in_valid   = 1'b0;
        in_len     = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;

        // R4 R5 R6: table walk, bucket starts full (R1)
        foreach (VEC[i]) begin
            police_send(VEC[i].len, VEC[i].conf, "R4/R6 table");
        end

        // R2: half a token per clock from an empty bucket
        cfg_rate = 16'h0080;
        police_send(16'd1, 1'b0, "R2 frac 0.5");
        police_send(16'd1, 1'b1, "R2 frac 1.5");
        police_send(16'd2, 1'b0, "R2 frac 1.5b");
        police_send(16'd2, 1'b1, "R2 frac 2.5");

        // R3: surplus credit is dropped at the depth
        cfg_depth = 20'd50;
        cfg_rate  = 16'h0A00;
        repeat (20) @(posedge clk);
        police_send(16'd51, 1'b0, "R3 cap");
        police_send(16'd50, 1'b1, "R3 full");

        // R7: shaper, depth 10, one token per clock
        cfg_police = 1'b0;
        cfg_depth  = 20'd10;
        cfg_rate   = 16'h0100;
        repeat (20) @(posedge clk);
        shape_send(16'd10, 1);
        shape_send(16'd5, 3);

        // R8: oversized descriptor never leaves
        @(negedge clk);
        in_valid = 1'b1;
        in_len   = 16'd11;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            check("R8 oversize no output", seen, 0);
        end
        check("R8 oversize blocks input", int'(in_ready), 0);

        // R1: reset clears a stuck slot
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 re-reset in_ready", int'(in_ready), 1);
        check("R1 re-reset out_valid", int'(out_valid), 0);

        summary();
        $finish;
    end
endmodule